// File: doc/BRIEF.md
# AU-4 Pointer Interpreter

This block follows the two-byte administrative-unit pointer that arrives once per frame and keeps track of where the payload container starts. The byte-position logic around it presents the H1 and H2 bytes together with a one-cycle frame tick. The interpreter keeps an accepted payload offset and a flag that says whether that offset can be trusted. It also reports justification events, new-data events, concatenation indication, loss of pointer and path AIS.

The accepted offset changes in only three ways. The first is a majority-voted inversion of the increment or decrement bit set. The second is a new-data flag that matches in at least three of its four bits. The third is the same new value received in three consecutive frames. The block does no payload extraction and has no byte counters. Downstream logic uses the offset and the event pulses to place the container.

Top module: `au_ptr_interp`

## Requirements
- R1: After reset, offset is 0 and offset_valid, just_inc, just_dec, new_data, concat, ptr_lost and path_ais are all 0.
- R2: The pointer word is {h1_in, h2_in}. Its flag field is h1_in[7:4] and its 10-bit value is {h1_in[1:0], h2_in}. A value in 0..782 is a legal offset, and offset 0 means the container starts at the byte right after the last H3.
- R3: When the flag field matches 1001 in at least three bit positions and the value is 0..782, the value is taken at once as the offset. The same tick sets offset_valid, clears ptr_lost and pulses new_data, whatever the current state.
- R4: The increment bits are value bits 9, 7, 5, 3 and 1. An increment is declared when all of these hold: offset_valid is 1, the flag field matches 0110 in at least three positions, at least 3 increment bits differ from the stored offset, and at most 2 decrement bits differ. The offset then rises by one (782 wraps to 0) and just_inc pulses. This check comes before the range check.
- R5: The decrement bits are value bits 8, 6, 4, 2 and 0. A decrement is declared under the same conditions with the roles of the two bit sets swapped. The offset then falls by one (0 wraps to 782) and just_dec pulses.
- R6: An inversion pattern is not a justification while offset_valid is 0 or while the flag field is not normal. It is then handled as a plain new value, with no pulse.
- R7: A legal value that differs from the accepted offset (or any legal value while offset_valid is 0) is accepted only when the same value arrives in three consecutive ticks. Any other word in between restarts the count. On acceptance offset_valid is set and ptr_lost is cleared.
- R8: A word whose flag field matches 1001 in three or more positions and whose value is all ones raises concat until the next non-concatenation word. It leaves the offset unchanged and gives no pulse.
- R9: A value above 782 that is neither a concatenation word nor a justification leaves the offset unchanged. Eight consecutive such words set ptr_lost and clear offset_valid. ptr_lost then stays set until an acceptance under R3 or R7.
- R10: An all-ones word (16'hFFFF) in three consecutive ticks sets path_ais. The first other word clears it. All-ones words also restart the invalid-word run.
- R11: Every output changes only in the cycle after a tick is sampled. just_inc, just_dec and new_data are single-cycle pulses, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe: h1_in/h2_in hold this frame's pointer |
| h1_in | input | 8 | First pointer byte |
| h2_in | input | 8 | Second pointer byte |
| offset | output | 10 | Accepted payload offset |
| offset_valid | output | 1 | Offset has been accepted and the pointer is not lost |
| just_inc | output | 1 | Pulse: positive justification accepted |
| just_dec | output | 1 | Pulse: negative justification accepted |
| new_data | output | 1 | Pulse: new-data-flag value taken |
| concat | output | 1 | Last word was a concatenation indication |
| ptr_lost | output | 1 | Loss of pointer |
| path_ais | output | 1 | Path AIS detected |

## Verification
All results come from registers written on the edge that samples frame_tick. Offset, flags and pulses are therefore due in the cycle right after that edge, and the pulses must be gone one cycle later. The bench raises the tick on a falling edge and compares every output at the next falling edge. It compares them again one cycle further on, expecting the pulses low and the offset held. The multi-frame rules (three-frame confirmation, eight-word loss, three-word AIS) are checked frame by frame, so the exact tick on which each one takes effect is observed.

// File: rtl/au_ptr_pkg.sv
`timescale 1ns/1ps
package au_ptr_pkg;
  localparam int unsigned VAL_W = 10;
  localparam logic [3:0] NFLAG_NEW  = 4'b1001;
  localparam logic [3:0] NFLAG_NORM = 4'b0110;
  localparam logic [VAL_W-1:0] INC_SET = 10'b10_1010_1010;
  localparam logic [VAL_W-1:0] DEC_SET = 10'b01_0101_0101;
  localparam logic [VAL_W-1:0] CONCAT_V = '1;

  typedef enum logic [2:0] {
    EV_AIS, EV_CI, EV_NDF, EV_INC, EV_DEC, EV_SAME, EV_NEW, EV_BAD
  } ptr_ev_e;

  function automatic logic vote3(input logic [3:0] fld, input logic [3:0] ref_code);
    return $countones(~(fld ^ ref_code)) >= 3;
  endfunction
endpackage

// File: rtl/au_ptr_decode.sv
`timescale 1ns/1ps
module au_ptr_decode
  import au_ptr_pkg::*;
#(
  parameter int unsigned MAX_OFS = 782
) (
  input  logic [15:0]      word,
  input  logic [VAL_W-1:0] cur_ofs,
  input  logic             cur_ok,
  output ptr_ev_e          ev
);
  localparam logic [VAL_W-1:0] MAX_V = MAX_OFS[VAL_W-1:0];

  logic [3:0]       nfld;
  logic [VAL_W-1:0] vfld;
  logic [VAL_W-1:0] diff;
  logic ndf_hit, norm_hit, i_maj, d_maj, in_range;

  always_comb begin
    nfld     = word[15:12];
    vfld     = word[VAL_W-1:0];
    diff     = vfld ^ cur_ofs;
    ndf_hit  = vote3(nfld, NFLAG_NEW);
    norm_hit = vote3(nfld, NFLAG_NORM);
    i_maj    = $countones(diff & INC_SET) >= 3;
    d_maj    = $countones(diff & DEC_SET) >= 3;
    in_range = vfld <= MAX_V;

    if (&word)                                      ev = EV_AIS;
    else if (ndf_hit && vfld == CONCAT_V)           ev = EV_CI;
    else if (ndf_hit && in_range)                   ev = EV_NDF;
    else if (cur_ok && norm_hit && i_maj && !d_maj) ev = EV_INC;
    else if (cur_ok && norm_hit && d_maj && !i_maj) ev = EV_DEC;
    else if (!in_range)                             ev = EV_BAD;
    else if (cur_ok && vfld == cur_ofs)             ev = EV_SAME;
    else                                            ev = EV_NEW;
  end
endmodule

// File: rtl/au_run_cnt.sv
`timescale 1ns/1ps
module au_run_cnt #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic step,
  output logic hit,
  output logic full
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM   = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    hit = tick && step && (cnt_q >= LIM_1);
    if (!step)            cnt_d = '0;
    else if (cnt_q == LIM) cnt_d = cnt_q;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign full = (cnt_q == LIM);
endmodule

// File: rtl/au_ptr_cand.sv
`timescale 1ns/1ps
module au_ptr_cand
  import au_ptr_pkg::*;
#(
  parameter int unsigned CONFIRM_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             track,
  input  logic [VAL_W-1:0] val,
  output logic             hit
);
  localparam int unsigned CW = $clog2(CONFIRM_N + 1);
  localparam logic [CW-1:0] LAST = CW'(CONFIRM_N - 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [VAL_W-1:0] val_q, val_d;
  logic             match;

  always_comb begin
    match = (cnt_q != '0) && (val == val_q);
    hit   = tick && track && match && (cnt_q == LAST);
    cnt_d = cnt_q;
    val_d = val_q;
    if (!track || hit) begin
      cnt_d = '0;
    end else if (match) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = CW'(1);
      val_d = val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      val_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_d;
      val_q <= val_d;
    end
  end
endmodule

// File: rtl/au_ptr_interp.sv
`timescale 1ns/1ps
module au_ptr_interp
  import au_ptr_pkg::*;
#(
  parameter int unsigned MAX_OFS   = 782,
  parameter int unsigned CONFIRM_N = 3,
  parameter int unsigned LOP_N     = 8,
  parameter int unsigned AIS_N     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [7:0]       h1_in,
  input  logic [7:0]       h2_in,
  output logic [VAL_W-1:0] offset,
  output logic             offset_valid,
  output logic             just_inc,
  output logic             just_dec,
  output logic             new_data,
  output logic             concat,
  output logic             ptr_lost,
  output logic             path_ais
);
  localparam logic [VAL_W-1:0] MAX_V = MAX_OFS[VAL_W-1:0];

  logic [15:0]      word;
  logic [VAL_W-1:0] rx_val;
  ptr_ev_e          ev;
  logic             cand_hit, bad_hit, bad_full, ais_hit;

  logic [VAL_W-1:0] ofs_q, ofs_d;
  logic ok_q, ok_d, lop_q, lop_d, ci_q, ci_d;
  logic inc_q, inc_d, dec_q, dec_d, ndf_q, ndf_d;

  assign word   = {h1_in, h2_in};
  assign rx_val = word[VAL_W-1:0];

  au_ptr_decode #(.MAX_OFS(MAX_OFS)) u_dec (
    .word    (word),
    .cur_ofs (ofs_q),
    .cur_ok  (ok_q),
    .ev      (ev)
  );

  au_ptr_cand #(.CONFIRM_N(CONFIRM_N)) u_cand (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (frame_tick),
    .track (ev == EV_NEW),
    .val   (rx_val),
    .hit   (cand_hit)
  );

  au_run_cnt #(.LIMIT(LOP_N)) u_bad_run (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (frame_tick),
    .step  (ev == EV_BAD),
    .hit   (bad_hit),
    .full  (bad_full)
  );

  au_run_cnt #(.LIMIT(AIS_N)) u_ais_run (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (frame_tick),
    .step  (ev == EV_AIS),
    .hit   (ais_hit),
    .full  (path_ais)
  );

  always_comb begin
    ofs_d = ofs_q;
    ok_d  = ok_q;
    lop_d = lop_q;
    ci_d  = ci_q;
    inc_d = 1'b0;
    dec_d = 1'b0;
    ndf_d = 1'b0;
    if (frame_tick) begin
      ci_d = (ev == EV_CI);
      unique case (ev)
        EV_NDF: begin
          ofs_d = rx_val;
          ok_d  = 1'b1;
          lop_d = 1'b0;
          ndf_d = 1'b1;
        end
        EV_INC: begin
          ofs_d = (ofs_q == MAX_V) ? '0 : ofs_q + VAL_W'(1);
          inc_d = 1'b1;
        end
        EV_DEC: begin
          ofs_d = (ofs_q == '0) ? MAX_V : ofs_q - VAL_W'(1);
          dec_d = 1'b1;
        end
        EV_NEW: begin
          if (cand_hit) begin
            ofs_d = rx_val;
            ok_d  = 1'b1;
            lop_d = 1'b0;
          end
        end
        EV_BAD: begin
          if (bad_hit || bad_full) begin
            lop_d = 1'b1;
            ok_d  = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      ok_q  <= 1'b0;
      lop_q <= 1'b0;
      ci_q  <= 1'b0;
      inc_q <= 1'b0;
      dec_q <= 1'b0;
      ndf_q <= 1'b0;
    end else begin
      ofs_q <= ofs_d;
      ok_q  <= ok_d;
      lop_q <= lop_d;
      ci_q  <= ci_d;
      inc_q <= inc_d;
      dec_q <= dec_d;
      ndf_q <= ndf_d;
    end
  end

  assign offset       = ofs_q;
  assign offset_valid = ok_q;
  assign ptr_lost     = lop_q;
  assign concat       = ci_q;
  assign just_inc     = inc_q;
  assign just_dec     = dec_q;
  assign new_data     = ndf_q;

  logic unused_ok;
  assign unused_ok = ais_hit;
endmodule

// File: rtl/au_ptr_interp_chk.sv
`timescale 1ns/1ps
module au_ptr_interp_chk #(
  parameter int unsigned MAX_OFS = 782
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick,
  input logic [9:0] offset,
  input logic       offset_valid,
  input logic       just_inc,
  input logic       just_dec,
  input logic       new_data,
  input logic       ptr_lost
);
  localparam logic [9:0] MAX_V = MAX_OFS[9:0];

  // R11
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({just_inc, just_dec, new_data}));

  // R11
  evt_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (just_inc || just_dec || new_data) |-> $past(frame_tick));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> ($stable(offset) && $stable(offset_valid)));

  // R4
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    just_inc |-> (offset == (($past(offset) == MAX_V) ? 10'd0 : $past(offset) + 10'd1)));

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    just_dec |-> (offset == (($past(offset) == 10'd0) ? MAX_V : $past(offset) - 10'd1)));

  // R9
  lost_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_lost |-> !offset_valid);

  // R2
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset <= MAX_V);

  // R3
  ndf_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_data |-> (offset_valid && !ptr_lost));
endmodule

bind au_ptr_interp au_ptr_interp_chk #(.MAX_OFS(MAX_OFS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_tick   (frame_tick),
  .offset       (offset),
  .offset_valid (offset_valid),
  .just_inc     (just_inc),
  .just_dec     (just_dec),
  .new_data     (new_data),
  .ptr_lost     (ptr_lost)
);

// File: tb/test_au_ptr_interp.sv
`timescale 1ns/1ps
module test_au_ptr_interp;
  localparam int unsigned MAXV = 782;
  localparam logic [9:0] IM = 10'b1010101010;
  localparam logic [9:0] DM = 10'b0101010101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] h1 = 8'h00;
  logic [7:0] h2 = 8'h00;
  logic [9:0] offset;
  logic offset_valid, just_inc, just_dec, new_data, concat, ptr_lost, path_ais;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  au_ptr_interp i_au_ptr_interp (
    .clk(clk), .rst_n(rst_n), .frame_tick(tick), .h1_in(h1), .h2_in(h2),
    .offset(offset), .offset_valid(offset_valid), .just_inc(just_inc),
    .just_dec(just_dec), .new_data(new_data), .concat(concat),
    .ptr_lost(ptr_lost), .path_ais(path_ais)
  );

  logic [9:0] m_ofs = 10'd0;
  logic [9:0] m_cval = 10'd0;
  bit m_ok = 0, m_lop = 0, m_ci = 0, m_ais = 0, m_inc = 0, m_dec = 0, m_ndf = 0;
  int m_brun = 0, m_arun = 0, m_ccnt = 0;

  function automatic logic [15:0] mk(input logic [3:0] n, input logic [9:0] v);
    return {n, 2'b10, v};
  endfunction

  function automatic int ones(input logic [15:0] x);
    return $countones(x);
  endfunction

  task automatic model(input logic [15:0] w);
    logic [9:0] v;
    bit nd, nn, im, dm;
    v  = w[9:0];
    nd = ones({12'd0, ~(w[15:12] ^ 4'b1001)}) >= 3;
    nn = ones({12'd0, ~(w[15:12] ^ 4'b0110)}) >= 3;
    im = ones({6'd0, (v ^ m_ofs) & IM}) >= 3;
    dm = ones({6'd0, (v ^ m_ofs) & DM}) >= 3;
    m_inc = 0; m_dec = 0; m_ndf = 0;
    if (w == 16'hFFFF) begin
      m_arun++; m_ais = (m_arun >= 3); m_brun = 0; m_ccnt = 0; m_ci = 0;
      return;
    end
    m_arun = 0; m_ais = 0;
    m_ci = nd && (v == 10'h3FF);
    if (m_ci) begin m_brun = 0; m_ccnt = 0; return; end
    if (nd && v <= MAXV) begin
      m_ofs = v; m_ok = 1; m_lop = 0; m_ndf = 1; m_brun = 0; m_ccnt = 0;
      return;
    end
    if (m_ok && nn && im && !dm) begin
      m_ofs = (m_ofs == MAXV) ? 10'd0 : m_ofs + 10'd1;
      m_inc = 1; m_brun = 0; m_ccnt = 0;
      return;
    end
    if (m_ok && nn && dm && !im) begin
      m_ofs = (m_ofs == 10'd0) ? 10'(MAXV) : m_ofs - 10'd1;
      m_dec = 1; m_brun = 0; m_ccnt = 0;
      return;
    end
    if (v > MAXV) begin
      m_ccnt = 0; m_brun++;
      if (m_brun >= 8) begin m_lop = 1; m_ok = 0; end
      return;
    end
    m_brun = 0;
    if (m_ok && v == m_ofs) begin m_ccnt = 0; return; end
    if (m_ccnt > 0 && v == m_cval) m_ccnt++;
    else begin m_cval = v; m_ccnt = 1; end
    if (m_ccnt >= 3) begin m_ofs = v; m_ok = 1; m_lop = 0; m_ccnt = 0; end
  endtask

  function automatic logic [16:0] exp_vec();
    return {m_ofs, m_ok, m_inc, m_dec, m_ndf, m_ci, m_lop, m_ais};
  endfunction

  function automatic logic [16:0] act_vec();
    return {offset, offset_valid, just_inc, just_dec, new_data, concat, ptr_lost, path_ais};
  endfunction

  task automatic check(input string tag, input logic [16:0] a, input logic [16:0] e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s: got ofs=%0d flags=%b expected ofs=%0d flags=%b",
               tag, a[16:7], a[6:0], e[16:7], e[6:0]);
    end
  endtask

  task automatic send(input logic [15:0] w, input string tag);
    @(negedge clk);
    tick = 1'b1; {h1, h2} = w;
    model(w);
    @(negedge clk);
    tick = 1'b0;
    check(tag, act_vec(), exp_vec());
    m_inc = 0; m_dec = 0; m_ndf = 0;
    @(negedge clk);
    check({"R11 pulse drop after ", tag}, act_vec(), exp_vec());
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: got hung run expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [9:0] v;
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", act_vec(), exp_vec());

    // R6: inversion pattern while offset_valid is 0 is no justification
    send(mk(4'b0110, IM), "R6 inc pattern before valid");
    // R2: offset 0 through new data, field positions
    send(mk(4'b1001, 10'd0), "R2 offset zero");
    // R3: new data flag with one flag bit wrong
    send(mk(4'b1011, 10'd781), "R3 ndf 3-of-4");
    // R4: increment and wrap
    send(mk(4'b0110, 10'd781 ^ IM), "R4 inc to 782");
    send(mk(4'b0110, 10'd782 ^ IM), "R4 inc wrap to 0");
    // R5: decrement and wrap
    send(mk(4'b0110, 10'd0 ^ DM), "R5 dec wrap to 782");
    send(mk(4'b0111, 10'd782 ^ DM), "R5 dec with one flag error");
    // R6: flag field not normal
    send(mk(4'b1111, 10'd781 ^ IM), "R6 inc with bad flags");
    // R7: confirmation restarts
    send(mk(4'b0110, 10'd100), "R7 new 1");
    send(mk(4'b0110, 10'd100), "R7 new 2");
    send(mk(4'b0110, 10'd200), "R7 interrupt");
    send(mk(4'b0110, 10'd100), "R7 restart 1");
    send(mk(4'b0110, 10'd100), "R7 restart 2");
    send(mk(4'b0110, 10'd100), "R7 accept");
    // R8: concatenation
    send(mk(4'b1001, 10'h3FF), "R8 concat");
    send(mk(4'b1000, 10'h3FF), "R8 concat 3-of-4");
    send(mk(4'b0110, 10'd100), "R8 concat clears");
    // R9: eight invalid words
    for (int i = 0; i < 8; i++) send(mk(4'b0110, 10'd900), "R9 invalid run");
    send(mk(4'b0110, 10'd100), "R9 lost persists");
    send(mk(4'b1001, 10'd55), "R9 lost cleared by ndf");
    // R10: path AIS
    for (int i = 0; i < 3; i++) send(16'hFFFF, "R10 ais run");
    send(mk(4'b0110, 10'd55), "R10 ais clears");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int kind;
      kind = int'($urandom_range(9, 0));
      case (kind)
        0: send(mk(4'b0110, m_ofs), "R7 rand same");
        1: send(mk(4'b0110, m_ofs ^ IM), "R4 rand inc");
        2: send(mk(4'b0110, m_ofs ^ DM), "R5 rand dec");
        3: send(mk(4'b1001, 10'($urandom_range(MAXV, 0))), "R3 rand ndf");
        4: begin
          v = 10'($urandom_range(MAXV, 0));
          for (int k = 0; k < 3; k++) send(mk(4'b0110, v), "R7 rand confirm");
        end
        5: begin
          int n;
          n = int'($urandom_range(9, 1));
          for (int k = 0; k < n; k++)
            send(mk(4'b0110, 10'($urandom_range(1022, MAXV + 1))), "R9 rand invalid");
        end
        6: send(mk(4'b1001, 10'h3FF), "R8 rand concat");
        7: begin
          int n;
          n = int'($urandom_range(4, 1));
          for (int k = 0; k < n; k++) send(16'hFFFF, "R10 rand ais");
        end
        8: send(16'($urandom()), "R2 rand word");
        default: send(mk(4'b0110, m_ofs) ^ (16'd1 << $urandom_range(15, 0)),
                      "R6 rand bit error");
      endcase
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule